// File: doc/BRIEF.md
# Four-Bit Mode-Selectable ALU Slice

This block is a four-bit arithmetic and logic slice. It takes two operands, a four-bit function code, a mode bit and a carry input. In logic mode it returns one of sixteen bitwise Boolean functions of the operands. In arithmetic mode it returns one of sixteen two's-complement sums. Each arithmetic entry is formed as X + Y + c, where X and Y are operand-derived words picked by the function code, and c is the carry input.

The carry input and the ripple carry output are both active-low. The slice also drives active-low group generate and group propagate outputs, so that several slices can be joined through an external look-ahead carry unit. An all-ones flag on the result gives operand equality when the slice is set to subtract with no borrow. In that same setting, the carry output gives the magnitude relation of the operands.

The core is combinational. Every output is captured in one register stage, so the results appear one clock after the inputs are sampled.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode`=1, `res_f` follows the bitwise map below, whatever the value of `carry_in_n`. The map is keyed by `fsel` in hex: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 zero, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), A B, B A&B, C all ones, D A|~B, E A|B, F A.
- R2: With `logic_mode`=0, `res_f` is the low four bits of X + Y + c, where c = 1 when `carry_in_n`=0 and c = 0 when `carry_in_n`=1. X and Y are keyed by `fsel` in hex: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (1111,0), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,1111), 8 (A,A&B), 9 (A,B), A (A|~B,A&B), B (A&B,1111), C (A,A), D (A|B,A), E (A|~B,A), F (A,1111).
- R3: `fsel`=1001 in arithmetic mode adds: A+B when `carry_in_n`=1 and A+B+1 when it is 0. `fsel`=0110 subtracts: A-B when `carry_in_n`=0 and A-B-1 when it is 1. Results wrap modulo 16.
- R4: In arithmetic mode, `fsel`=0000 transfers A, `fsel`=1100 doubles A, `fsel`=1111 decrements A and `fsel`=0011 gives all ones. In each of these, `carry_in_n`=0 adds one.
- R5: `carry_out_n` is the inverse of bit 4 of the R2 sum. It is produced in both modes.
- R6: `grp_gen_n` is 0 exactly when X + Y overflows four bits with no carry in. `grp_prop_n` is 0 exactly when every bit of X|Y is 1. Neither depends on `logic_mode` or `carry_in_n`.
- R7: `eq_all` is 1 exactly when all four bits of `res_f` are 1. With `fsel`=0110, `logic_mode`=0 and `carry_in_n`=1, this means A equals B.
- R8: With `fsel`=0110, `logic_mode`=0 and `carry_in_n`=1, `carry_out_n` is 1 when A <= B and 0 when A > B (unsigned).
- R9: Every output shows the inputs sampled at the previous rising clock edge. An active-low asynchronous `rst_n` forces all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| fsel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = bitwise functions, 0 = arithmetic |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| res_f | output | 4 | Registered result |
| carry_out_n | output | 1 | Registered active-low carry out of bit 3 |
| grp_gen_n | output | 1 | Registered active-low group generate |
| grp_prop_n | output | 1 | Registered active-low group propagate |
| eq_all | output | 1 | Registered all-ones flag of the result |

## Verification
The slice holds no state apart from its output register. A wrong per-bit term or a wrong carry appears at the ports in the very next registered result, one clock after the offending inputs. A carry fault shows only for operand pairs that exercise that carry chain. For that reason every combination of operands, code, mode and carry is driven, and the four port groups are compared against a model built from the X/Y map. Subtract-mode equality and magnitude are swept separately over all operand pairs.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;
    typedef logic [3:0] fsel_t;

    localparam fsel_t SEL_PASS = 4'b0000;
    localparam fsel_t SEL_SUB  = 4'b0110;
    localparam fsel_t SEL_ADD  = 4'b1001;
endpackage

// File: rtl/alu4_bit_terms.sv
`timescale 1ns/1ps
module alu4_bit_terms #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  alu4_pkg::fsel_t    sel,
    output logic [WIDTH-1:0]   prop,
    output logic [WIDTH-1:0]   gen,
    output logic [WIDTH-1:0]   half
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic x_n;
        logic y_n;
        // x_n: inverted propagate, y_n: inverted generate
        assign x_n     = ~(op_a[i] | (op_b[i] & sel[0]) | (~op_b[i] & sel[1]));
        assign y_n     = ~((op_a[i] & ~op_b[i] & sel[2]) | (op_a[i] & op_b[i] & sel[3]));
        assign prop[i] = ~x_n;
        assign gen[i]  = ~y_n;
        assign half[i] = x_n ^ y_n;
    end
endmodule

// File: rtl/alu4_carry_la.sv
`timescale 1ns/1ps
module alu4_carry_la #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             cin,
    output logic [WIDTH:0]   carry,
    output logic             grp_g,
    output logic             grp_p
);
    // AND of prop[lo .. hi-1]; 1 when the span is empty
    function automatic logic span_and(input logic [WIDTH-1:0] p, input int lo, input int hi);
        logic r;
        r = 1'b1;
        for (int k = 0; k < WIDTH; k++) begin
            if (k >= lo && k < hi) r = r & p[k];
        end
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i <= WIDTH; i++) begin
            carry[i] = cin & span_and(prop, 0, i);
            for (int j = 0; j < WIDTH; j++) begin
                if (j < i) carry[i] = carry[i] | (gen[j] & span_and(prop, j + 1, i));
            end
        end
        grp_g = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            grp_g = grp_g | (gen[j] & span_and(prop, j + 1, WIDTH));
        end
        grp_p = &prop;
    end
endmodule

// File: rtl/alu4_slice.sv
`timescale 1ns/1ps
module alu4_slice #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       fsel,
    input  logic             logic_mode,
    input  logic             carry_in_n,
    output logic [WIDTH-1:0] res_f,
    output logic             carry_out_n,
    output logic             grp_gen_n,
    output logic             grp_prop_n,
    output logic             eq_all
);
    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             cout_n;
        logic             gen_n;
        logic             prop_n;
        logic             eq;
    } slice_out_t;

    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] half;
    logic [WIDTH:0]   carry;
    logic             grp_g;
    logic             grp_p;
    slice_out_t       out_d;
    slice_out_t       out_q;

    alu4_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .op_a (op_a),
        .op_b (op_b),
        .sel  (fsel),
        .prop (prop),
        .gen  (gen),
        .half (half)
    );

    alu4_carry_la #(.WIDTH(WIDTH)) u_carry (
        .prop  (prop),
        .gen   (gen),
        .cin   (~carry_in_n),
        .carry (carry),
        .grp_g (grp_g),
        .grp_p (grp_p)
    );

    always_comb begin
        out_d.f      = half ^ (carry[WIDTH-1:0] | {WIDTH{logic_mode}});
        out_d.cout_n = ~carry[WIDTH];
        out_d.gen_n  = ~grp_g;
        out_d.prop_n = ~grp_p;
        out_d.eq     = &out_d.f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_f       = out_q.f;
    assign carry_out_n = out_q.cout_n;
    assign grp_gen_n   = out_q.gen_n;
    assign grp_prop_n  = out_q.prop_n;
    assign eq_all      = out_q.eq;
endmodule

// File: rtl/alu4_slice_chk.sv
`timescale 1ns/1ps
module alu4_slice_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       fsel,
    input logic             logic_mode,
    input logic             carry_in_n,
    input logic [WIDTH-1:0] res_f,
    input logic             carry_out_n,
    input logic             eq_all
);
    import alu4_pkg::*;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_EQ_TRACKS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        eq_all == (&res_f)); // R7

    AST_SUB_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(fsel == SEL_SUB && !logic_mode && carry_in_n)
        |-> carry_out_n == ($past(op_a) <= $past(op_b))); // R8

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(fsel == SEL_ADD && !logic_mode && carry_in_n)
        |-> res_f == WIDTH'($past(op_a) + $past(op_b))); // R3

    AST_LOGIC_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(fsel == SEL_SUB && logic_mode)
        |-> res_f == ($past(op_a) ^ $past(op_b))); // R1

    AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(fsel == SEL_PASS && !logic_mode && carry_in_n)
        |-> res_f == $past(op_a)); // R4
endmodule

bind alu4_slice alu4_slice_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a        (op_a),
    .op_b        (op_b),
    .fsel        (fsel),
    .logic_mode  (logic_mode),
    .carry_in_n  (carry_in_n),
    .res_f       (res_f),
    .carry_out_n (carry_out_n),
    .eq_all      (eq_all)
);

// File: tb/alu4_slice_bench.sv
`timescale 1ns/1ps
module alu4_slice_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] fsel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in_n = 1'b1;
    logic [3:0] res_f;
    logic       carry_out_n;
    logic       grp_gen_n;
    logic       grp_prop_n;
    logic       eq_all;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    alu4_slice u_alu4_slice (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fsel(fsel),
        .logic_mode(logic_mode), .carry_in_n(carry_in_n), .res_f(res_f),
        .carry_out_n(carry_out_n), .grp_gen_n(grp_gen_n),
        .grp_prop_n(grp_prop_n), .eq_all(eq_all)
    );

    // fields: [17] mode, [16] carry_in_n, [15:12] fsel, [11:8] A, [7:4] B, [3:0] F
    localparam int NV = 22;
    localparam logic [17:0] VTAB [NV] = '{
        {1'b0,1'b1,4'h9,4'h5,4'h3,4'h8}, {1'b0,1'b0,4'h9,4'h5,4'h3,4'h9},
        {1'b0,1'b1,4'h9,4'hF,4'h1,4'h0}, {1'b0,1'b0,4'h6,4'h7,4'h2,4'h5},
        {1'b0,1'b1,4'h6,4'h7,4'h2,4'h4}, {1'b0,1'b0,4'h6,4'h2,4'h7,4'hB},
        {1'b0,1'b1,4'h0,4'hA,4'h0,4'hA}, {1'b0,1'b0,4'h0,4'hA,4'h0,4'hB},
        {1'b0,1'b1,4'hC,4'h6,4'h0,4'hC}, {1'b0,1'b1,4'hF,4'h0,4'h0,4'hF},
        {1'b0,1'b0,4'hF,4'h0,4'h0,4'h0}, {1'b0,1'b1,4'h3,4'h5,4'h5,4'hF},
        {1'b0,1'b0,4'h3,4'h5,4'h5,4'h0}, {1'b1,1'b1,4'h6,4'hC,4'hA,4'h6},
        {1'b1,1'b0,4'h6,4'hC,4'hA,4'h6}, {1'b1,1'b1,4'hB,4'hC,4'hA,4'h8},
        {1'b1,1'b1,4'hE,4'hC,4'hA,4'hE}, {1'b1,1'b0,4'h9,4'hC,4'hA,4'h9},
        {1'b1,1'b1,4'h0,4'hC,4'h5,4'h3}, {1'b1,1'b1,4'h3,4'hC,4'h5,4'h0},
        {1'b1,1'b0,4'hC,4'hC,4'h5,4'hF}, {1'b1,1'b1,4'hF,4'hC,4'h5,4'hC}
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (s=%h m=%b cn=%b a=%h b=%h)",
                     tag, act, exp, fsel, logic_mode, carry_in_n, op_a, op_b);
        end
    endtask

    // drive at a falling edge, let one rising edge capture, return at the next falling edge
    task automatic apply(input logic m, input logic cn, input logic [3:0] s,
                         input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        logic_mode = m; carry_in_n = cn; fsel = s; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    function automatic void xy_ref(input logic [3:0] s, input logic [3:0] a,
                                   input logic [3:0] b, output logic [3:0] x,
                                   output logic [3:0] y);
        case (s)
            4'h0: begin x = a;      y = 4'h0;   end
            4'h1: begin x = a | b;  y = 4'h0;   end
            4'h2: begin x = a | ~b; y = 4'h0;   end
            4'h3: begin x = 4'hF;   y = 4'h0;   end
            4'h4: begin x = a;      y = a & ~b; end
            4'h5: begin x = a | b;  y = a & ~b; end
            4'h6: begin x = a;      y = ~b;     end
            4'h7: begin x = a & ~b; y = 4'hF;   end
            4'h8: begin x = a;      y = a & b;  end
            4'h9: begin x = a;      y = b;      end
            4'hA: begin x = a | ~b; y = a & b;  end
            4'hB: begin x = a & b;  y = 4'hF;   end
            4'hC: begin x = a;      y = a;      end
            4'hD: begin x = a | b;  y = a;      end
            4'hE: begin x = a | ~b; y = a;      end
            default: begin x = a;   y = 4'hF;   end
        endcase
    endfunction

    function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] a,
                                             input logic [3:0] b);
        case (s)
            4'h0: return ~a;
            4'h1: return ~(a | b);
            4'h2: return ~a & b;
            4'h3: return 4'h0;
            4'h4: return ~(a & b);
            4'h5: return ~b;
            4'h6: return a ^ b;
            4'h7: return a & ~b;
            4'h8: return ~a | b;
            4'h9: return ~(a ^ b);
            4'hA: return b;
            4'hB: return a & b;
            4'hC: return 4'hF;
            4'hD: return a | ~b;
            4'hE: return a | b;
            default: return a;
        endcase
    endfunction

    initial begin : watchdog
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] x, y, f_exp;
        logic [4:0] sum5, gsum;
        // R9: reset state
        repeat (2) @(negedge clk);
        check({res_f}, 4'h0, "R9 reset res_f");
        check({carry_out_n, grp_gen_n, grp_prop_n, eq_all}, 4'h0, "R9 reset flags");
        rst_n = 1'b1;

        // table walk: R1 logic rows, R3 add/sub rows, R4 transfer/double/decrement/all-ones rows
        for (int i = 0; i < NV; i++) begin
            apply(VTAB[i][17], VTAB[i][16], VTAB[i][15:12], VTAB[i][11:8], VTAB[i][7:4]);
            check(res_f, VTAB[i][3:0], VTAB[i][17] ? "R1 table" : "R3/R4 table");
        end

        // exhaustive: R2 R5 R6 R7 against X/Y model
        for (int v = 0; v < 16384; v++) begin
            apply(v[13], v[12], v[11:8], v[7:4], v[3:0]);
            xy_ref(fsel, op_a, op_b, x, y);
            sum5  = {1'b0, x} + {1'b0, y} + {4'b0, ~carry_in_n};
            gsum  = {1'b0, x} + {1'b0, y};
            f_exp = logic_mode ? logic_ref(fsel, op_a, op_b) : sum5[3:0];
            check(res_f, f_exp, logic_mode ? "R1 logic" : "R2 arith");
            check({3'b0, carry_out_n}, {3'b0, ~sum5[4]}, "R5 carry_out_n");
            check({2'b0, grp_gen_n, grp_prop_n}, {2'b0, ~gsum[4], ~(&(x | y))}, "R6 group");
            check({3'b0, eq_all}, {3'b0, &f_exp}, "R7 eq_all");
        end

        // R7 R8: subtract with no borrow, all operand pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(1'b0, 1'b1, 4'h6, 4'(a), 4'(b));
                check({3'b0, eq_all}, {3'b0, a == b}, "R7 equality");
                check({3'b0, carry_out_n}, {3'b0, a <= b}, "R8 magnitude");
            end
        end

        // R9: one-cycle latency then asynchronous clear
        apply(1'b0, 1'b1, 4'h9, 4'h2, 4'h3);
        @(negedge clk);
        logic_mode = 1'b0; carry_in_n = 1'b1; fsel = 4'h9; op_a = 4'h7; op_b = 4'h7;
        #2;
        check(res_f, 4'h5, "R9 holds until edge");
        @(negedge clk);
        check(res_f, 4'hE, "R9 updates after edge");
        #2 rst_n = 1'b0;
        #1;
        check(res_f, 4'h0, "R9 async clear");
        check({carry_out_n, grp_gen_n, grp_prop_n, eq_all}, 4'h0, "R9 async clear flags");
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 1'b0, 4'hC, 4'h0, 4'h0);
        check(res_f, 4'hF, "R1 after reset release");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule